// File: doc/BRIEF.md
# Gated Multi-Channel Counter Bank

This block holds a small bank of 16-bit up-counters. Each channel has a count value, a compare target and a mode word, and all three sit behind a register window. A channel advances on every system clock, or on an external tick when its clock-select bit is set. The last channel's external source is the system clock divided by eight, made inside the block. Each channel has a gate input. Depending on the sync setting in the mode word, the gate can freeze the count, zero it, let it run only while high, or release the channel into free running after its first rising edge.

A channel wraps either at its target or at the all-ones value. When it wraps, it records a target-reached flag and an overflow flag. Reading the mode word returns these flags and then clears them. A per-channel interrupt line pulses for one cycle when the enabled flag condition changes from 0 to 1. An interrupt controller and a bus bridge sit outside the block.

Top module: `tick_counter_bank`

## Requirements
- R1: Address bits [5:4] pick the channel and bits [3:0] pick the register: 0x0 count, 0x4 mode, 0x8 target. The read value appears on `rdata_o` the cycle after the read strobe. A read of any other offset, or of a channel number that does not exist (3 with the default three channels), returns 0xFFFFFFFF.
- R2: A write to the count or the target stores only bits [15:0] of the bus. A count write made in the same cycle as a count advance wins over the advance.
- R3: A mode write stores bits [12:0] of the bus and forces the counter to zero. Bit 10 is owned by the hardware: it reads back as the current interrupt condition (see R7).
- R4: By default a channel advances once per system clock. Channels 0 and 1 count `ext_tick_i` pulses when mode bit 8 is set, and ignore bit 9. The last channel uses bit 9 to select a tick that occurs on every eighth system clock.
- R5: With mode bit 3 set, the counter returns to zero when an advance would reach the target. With bit 3 clear, it returns to zero when an advance would reach 0xFFFF, so the value 0xFFFF is never held. A wrap value of zero keeps the counter at zero.
- R6: On a wrap, mode bit 11 sets if the new value is at or above the target, and bit 12 sets if it is at or above 0xFFFF. A mode read returns the word and then clears both bits. A flag set by a wrap in the same cycle as that read survives the read.
- R7: `irq_o[c]` pulses for exactly one cycle when (bit 11 AND bit 4) OR (bit 12 AND bit 5) of channel c goes from 0 to 1. It does not pulse again while that condition stays high.
- R8: With mode bit 0 (sync enable) clear, the gate input has no effect.
- R9: Sync mode 0 (bits [2:1] = 0): the count holds while the gate is high.
- R10: Sync mode 1: a rising gate zeroes the counter, and the channel counts whatever the gate level.
- R11: Sync mode 2: a rising gate zeroes the counter, and the channel counts only while the gate is high.
- R12: Sync mode 3: the channel counts only while the gate is low. A rising gate clears mode bit 0, and from then on the channel runs freely.
- R13: After reset, every mode word, count, target and registered gate copy is zero, and every channel counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 6 | Byte offset in the register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| gate_i | input | 3 | Gate level, one per channel |
| ext_tick_i | input | 2 | External tick enable for channels 0 and 1 |
| irq_o | output | 3 | One-cycle interrupt pulse per channel |

## Verification
Two things can land on a single clock edge: the read that clears a channel's flags, and a wrap that sets them. The bench forces this collision by giving a free-running channel a target of 3 and timing a mode read for the edge on which the count wraps. It expects that read to show the flag clear, the next read to show the target flag set, and the read after that to show it cleared. A count write is also placed on an edge where a free-running channel would advance. That case is judged by the value read back on the following two cycles.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

   localparam int MODE_W = 13;

   localparam logic [3:0] OFS_COUNT  = 4'h0;
   localparam logic [3:0] OFS_MODE   = 4'h4;
   localparam logic [3:0] OFS_TARGET = 4'h8;

   typedef enum logic [1:0] {
      SYNC_HOLD_HI   = 2'd0,
      SYNC_ZERO_RISE = 2'd1,
      SYNC_RUN_HI    = 2'd2,
      SYNC_FREE_RISE = 2'd3
   } sync_e;

   // packed MSB first: [12] ovf, [11] tgt, [10] irq level, [9:8] clock select,
   // [7] pulse, [6] repeat, [5] irq on ovf, [4] irq on tgt, [3] wrap at tgt,
   // [2:1] sync mode, [0] sync enable
   typedef struct packed {
      logic       ovf_hit;
      logic       tgt_hit;
      logic       irq_lvl;
      logic [1:0] clk_sel;
      logic       pulse;
      logic       repeat_en;
      logic       irq_ovf_en;
      logic       irq_tgt_en;
      logic       wrap_tgt;
      sync_e      sync_sel;
      logic       sync_en;
   } mode_t;

endpackage

// File: rtl/tcb_prescaler.sv
module tcb_prescaler #(
   parameter int DIV_LOG2 = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic tick_o
);

   if (DIV_LOG2 < 1) begin : g_bad_div
      $error("tcb_prescaler: DIV_LOG2 must be at least 1");
   end

   logic [DIV_LOG2-1:0] div_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) div_q <= '0;
      else         div_q <= div_q + 1'b1;
   end

   assign tick_o = &div_q;

   // R4: divided tick never occupies two adjacent cycles
   p_div_space_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);

endmodule

// File: rtl/tcb_gate_ctrl.sv
module tcb_gate_ctrl
   import tcb_pkg::*;
(
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  gate_i,
   input  logic  sync_en_i,
   input  sync_e sync_sel_i,
   output logic  run_o,
   output logic  zero_o,
   output logic  unsync_o
);

   logic gate_q;
   logic rise;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) gate_q <= 1'b0;
      else         gate_q <= gate_i;
   end

   assign rise = gate_i & ~gate_q;

   always_comb begin
      run_o    = 1'b1;
      zero_o   = 1'b0;
      unsync_o = 1'b0;
      if (sync_en_i) begin
         unique case (sync_sel_i)
            SYNC_HOLD_HI:   run_o = ~gate_i;
            SYNC_ZERO_RISE: zero_o = rise;
            SYNC_RUN_HI: begin
               run_o  = gate_i;
               zero_o = rise;
            end
            SYNC_FREE_RISE: begin
               run_o    = ~gate_i;
               unsync_o = rise;
            end
            default: run_o = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/tcb_irq_edge.sv
module tcb_irq_edge (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic cond_i,
   output logic pulse_o
);

   logic prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= cond_i;
   end

   assign pulse_o = cond_i & ~prev_q;

   // R7: a pulse lasts one cycle only
   p_irq_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_o |=> !pulse_o);

endmodule

// File: rtl/tcb_channel.sv
module tcb_channel
   import tcb_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int IN_W        = 16,
   parameter int EXT_SEL_BIT = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_cnt_i,
   input  logic              wr_mode_i,
   input  logic              wr_tgt_i,
   input  logic              rd_mode_i,
   input  logic [IN_W-1:0]   wdata_i,
   input  logic              gate_i,
   input  logic              ext_tick_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [CNT_W-1:0]  tgt_o,
   output logic [MODE_W-1:0] mode_o,
   output logic              irq_o
);

   if (EXT_SEL_BIT < 0 || EXT_SEL_BIT > 1) begin : g_bad_sel
      $error("tcb_channel: EXT_SEL_BIT must be 0 or 1");
   end

   localparam logic [CNT_W:0] TOP_VAL = {1'b0, {CNT_W{1'b1}}};

   mode_t            mode_q, mode_d, mode_rd;
   logic [CNT_W-1:0] cnt_q, cnt_d, tgt_q, tgt_d;
   logic [CNT_W:0]   nxt, wrap_at;
   logic             run, zero_req, drop_sync, tick, adv, hit, cond;

   tcb_gate_ctrl i_gate (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .gate_i     (gate_i),
      .sync_en_i  (mode_q.sync_en),
      .sync_sel_i (mode_q.sync_sel),
      .run_o      (run),
      .zero_o     (zero_req),
      .unsync_o   (drop_sync)
   );

   assign tick    = mode_q.clk_sel[EXT_SEL_BIT] ? ext_tick_i : 1'b1;
   assign adv     = run & tick & ~zero_req & ~wr_cnt_i & ~wr_mode_i;
   assign nxt     = {1'b0, cnt_q} + (CNT_W+1)'(1);
   assign wrap_at = mode_q.wrap_tgt ? {1'b0, tgt_q} : TOP_VAL;
   assign hit     = adv & (nxt >= wrap_at);

   always_comb begin
      cnt_d = cnt_q;
      if (wr_cnt_i)                    cnt_d = wdata_i[CNT_W-1:0];
      else if (wr_mode_i || zero_req)  cnt_d = '0;
      else if (hit)                    cnt_d = '0;
      else if (adv)                    cnt_d = nxt[CNT_W-1:0];
   end

   always_comb begin
      tgt_d = wr_tgt_i ? wdata_i[CNT_W-1:0] : tgt_q;
   end

   always_comb begin
      mode_d = mode_q;
      if (wr_mode_i) begin
         mode_d         = mode_t'(wdata_i[MODE_W-1:0]);
         mode_d.irq_lvl = 1'b0;
      end else begin
         if (rd_mode_i) begin
            mode_d.tgt_hit = 1'b0;
            mode_d.ovf_hit = 1'b0;
         end
         if (hit && nxt >= {1'b0, tgt_q}) mode_d.tgt_hit = 1'b1;
         if (hit && nxt >= TOP_VAL)       mode_d.ovf_hit = 1'b1;
         if (drop_sync)                   mode_d.sync_en = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         tgt_q  <= '0;
         mode_q <= '0;
      end else begin
         cnt_q  <= cnt_d;
         tgt_q  <= tgt_d;
         mode_q <= mode_d;
      end
   end

   assign cond = (mode_q.tgt_hit & mode_q.irq_tgt_en) |
                 (mode_q.ovf_hit & mode_q.irq_ovf_en);

   tcb_irq_edge i_irq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cond_i  (cond),
      .pulse_o (irq_o)
   );

   always_comb begin
      mode_rd         = mode_q;
      mode_rd.irq_lvl = cond;
   end

   assign mode_o = mode_rd;
   assign cnt_o  = cnt_q;
   assign tgt_o  = tgt_q;

   // R3: a mode write leaves the counter at zero
   p_mode_wr_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_mode_i |=> (cnt_q == '0));

   // R2: a count write lands even when an advance was due
   p_cnt_wr_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_cnt_i |=> (cnt_q == $past(wdata_i[CNT_W-1:0])));

   // R9: while the gate logic withholds counting, the count holds
   p_paused_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run && !wr_cnt_i && !wr_mode_i) |=> $stable(cnt_q));

   // R6: a mode read with no wrap in that cycle leaves both flags clear
   p_rd_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_mode_i && !wr_mode_i && !hit) |=> (!mode_q.tgt_hit && !mode_q.ovf_hit));

endmodule

// File: rtl/tick_counter_bank.sv
module tick_counter_bank
   import tcb_pkg::*;
#(
   parameter int NUM_CH   = 3,
   parameter int CNT_W    = 16,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 6,
   parameter int DIV_LOG2 = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [NUM_CH-1:0] gate_i,
   input  logic [NUM_CH-2:0] ext_tick_i,
   output logic [NUM_CH-1:0] irq_o
);

   localparam int CH_W = ADDR_W - 4;
   localparam int IN_W = (CNT_W > MODE_W) ? CNT_W : MODE_W;

   if (ADDR_W < 5) begin : g_bad_addr
      $error("tick_counter_bank: ADDR_W too small for channel select");
   end
   if (NUM_CH < 2 || NUM_CH > (1 << CH_W)) begin : g_bad_nch
      $error("tick_counter_bank: NUM_CH out of range for address window");
   end
   if (CNT_W < 2 || CNT_W > DATA_W || MODE_W > DATA_W) begin : g_bad_w
      $error("tick_counter_bank: register widths do not fit the data bus");
   end

   logic [CH_W-1:0]   ch_idx;
   logic [3:0]        ofs;
   logic [CNT_W-1:0]  cnt_a  [NUM_CH];
   logic [CNT_W-1:0]  tgt_a  [NUM_CH];
   logic [MODE_W-1:0] mode_a [NUM_CH];
   logic [DATA_W-1:0] rd_val;
   logic              rd_known;
   logic              presc_tick;
   logic              unused_hi;

   assign ch_idx    = addr_i[ADDR_W-1:4];
   assign ofs       = addr_i[3:0];
   assign unused_hi = ^wdata_i;

   tcb_prescaler #(.DIV_LOG2(DIV_LOG2)) i_presc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_o (presc_tick)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic sel, ext;
      assign sel = (ch_idx == CH_W'(g));

      if (g == NUM_CH - 1) begin : g_div_src
         assign ext = presc_tick;
      end else begin : g_pin_src
         assign ext = ext_tick_i[g];
      end

      tcb_channel #(
         .CNT_W       (CNT_W),
         .IN_W        (IN_W),
         .EXT_SEL_BIT ((g == NUM_CH - 1) ? 1 : 0)
      ) i_chan (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .wr_cnt_i   (wr_en_i & sel & (ofs == OFS_COUNT)),
         .wr_mode_i  (wr_en_i & sel & (ofs == OFS_MODE)),
         .wr_tgt_i   (wr_en_i & sel & (ofs == OFS_TARGET)),
         .rd_mode_i  (rd_en_i & sel & (ofs == OFS_MODE)),
         .wdata_i    (wdata_i[IN_W-1:0]),
         .gate_i     (gate_i[g]),
         .ext_tick_i (ext),
         .cnt_o      (cnt_a[g]),
         .tgt_o      (tgt_a[g]),
         .mode_o     (mode_a[g]),
         .irq_o      (irq_o[g])
      );
   end

   always_comb begin
      rd_val   = '1;
      rd_known = 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (ch_idx == CH_W'(i)) begin
            unique case (ofs)
               OFS_COUNT: begin
                  rd_val   = DATA_W'(cnt_a[i]);
                  rd_known = 1'b1;
               end
               OFS_MODE: begin
                  rd_val   = DATA_W'(mode_a[i]);
                  rd_known = 1'b1;
               end
               OFS_TARGET: begin
                  rd_val   = DATA_W'(tgt_a[i]);
                  rd_known = 1'b1;
               end
               default: rd_known = 1'b0;
            endcase
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rdata_o <= '0;
      else if (rd_en_i) rdata_o <= rd_val;
   end

   // R1: reads outside the decoded registers return all ones
   p_bad_read_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && !rd_known) |=> (rdata_o == '1));

endmodule

// File: tb/test_tick_counter_bank.sv
module test_tick_counter_bank;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [2:0]  gate = 3'b011;
   logic [1:0]  ext_tick = '0;
   logic [2:0]  irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   tick_counter_bank i_tick_counter_bank (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .wr_en_i    (wr_en),
      .rd_en_i    (rd_en),
      .addr_i     (addr),
      .wdata_i    (wdata),
      .rdata_o    (rdata),
      .gate_i     (gate),
      .ext_tick_i (ext_tick),
      .irq_o      (irq)
   );

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } exp_t;

   exp_t sb_q[$];
   int   n_checks = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   task automatic note(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // driver: pushes the expected read value, then issues the read
   task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
      exp_t e;
      e.exp = exp;
      e.tag = tag;
      sb_q.push_back(e);
      rd_en = 1'b1;
      addr  = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      wr_en = 1'b1;
      addr  = a;
      wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_irq(input int ch, input logic exp, input string tag);
      note(irq[ch] === exp, tag, 32'(irq[ch]), 32'(exp));
   endtask

   // monitor: compares read data one step after the capturing edge
   initial begin
      logic cap;
      exp_t e;
      forever begin
         @(posedge clk);
         cap = rd_en;
         #1;
         if (cap) begin
            if (sb_q.size() == 0) begin
               note(1'b0, "R1 unexpected read", rdata, 32'h0);
            end else begin
               e = sb_q.pop_front();
               note(rdata === e.exp, e.tag, rdata, e.exp);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R13: reset state
      chk_irq(0, 1'b0, "R13 irq idle after reset");
      rd(6'h00, 32'h0, "R13 count ch0 after reset");
      rd(6'h04, 32'h0, "R13 mode ch0 after reset");
      rd(6'h08, 32'h0, "R13 target ch0 after reset");
      rd(6'h18, 32'h0, "R13 target ch1 after reset");
      rd(6'h24, 32'h0, "R13 mode ch2 after reset");

      // R1: undecoded offsets and channels
      rd(6'h0C, 32'hFFFF_FFFF, "R1 unknown offset");
      rd(6'h34, 32'hFFFF_FFFF, "R1 missing channel");

      // R2: target keeps low 16 bits
      wr(6'h18, 32'hABCD_1234);
      rd(6'h18, 32'h0000_1234, "R2 target masking");

      // ch0: wrap at target 5, irq on target, sync mode 0 pause
      wr(6'h08, 32'h5);
      wr(6'h04, 32'h19);
      rd(6'h00, 32'h0, "R9 paused after mode write");
      idle(3);
      rd(6'h00, 32'h0, "R9 still paused with gate high");
      gate[0] = 1'b0;
      idle(4);
      chk_irq(0, 1'b0, "R7 no irq before wrap");
      idle(1);
      chk_irq(0, 1'b1, "R7 irq pulse on target wrap");
      gate[0] = 1'b1;
      idle(1);
      chk_irq(0, 1'b0, "R7 pulse is one cycle");
      rd(6'h00, 32'h0, "R5 counter wrapped at target");
      gate[0] = 1'b0;
      for (int i = 0; i < 5; i++) begin
         idle(1);
         chk_irq(0, 1'b0, "R7 no repeat while condition high");
      end
      gate[0] = 1'b1;
      rd(6'h04, 32'h0C19, "R6 target flag and irq level");
      rd(6'h04, 32'h0019, "R6 flags cleared by read");

      // ch1: overflow wrap
      wr(6'h14, 32'h21);
      wr(6'h10, 32'h5A5A_FFFD);
      rd(6'h10, 32'h0000_FFFD, "R2 count masking");
      gate[1] = 1'b0;
      idle(1);
      chk_irq(1, 1'b0, "R7 no irq before overflow");
      idle(1);
      chk_irq(1, 1'b1, "R7 irq pulse on overflow");
      gate[1] = 1'b1;
      rd(6'h10, 32'h0, "R5 counter wrapped at 0xFFFF");
      rd(6'h14, 32'h1C21, "R6 overflow and target flags");

      // R2: count write beats the advance on free-running ch2
      wr(6'h20, 32'h1234);
      rd(6'h20, 32'h1234, "R2 write wins over count");
      rd(6'h20, 32'h1235, "R4 counts each system clock");

      // R4: ch2 divided source
      wr(6'h24, 32'h200);
      rd(6'h20, 32'h0, "R4 divided source start");
      idle(63);
      rd(6'h20, 32'h8, "R4 eight ticks in 64 cycles");

      // R4/R3: ch0 external ticks, mode masking
      wr(6'h04, 32'hFFFF_E100);
      rd(6'h04, 32'h0100, "R3 mode keeps low 13 bits");
      rd(6'h00, 32'h0, "R4 no ext ticks yet");
      for (int i = 0; i < 3; i++) begin
         ext_tick[0] = 1'b1;
         idle(1);
         ext_tick[0] = 1'b0;
         idle(1);
      end
      rd(6'h00, 32'h3, "R4 counts external ticks");

      // R4/R8: ch1 bit 9 ignored, gate high ignored with sync off
      wr(6'h14, 32'h200);
      rd(6'h10, 32'h0, "R8 gate ignored start");
      rd(6'h10, 32'h1, "R8 counts with gate high, bit9 ignored");

      // R6: read-clear and wrap in the same cycle
      wr(6'h08, 32'h3);
      wr(6'h04, 32'h008);
      idle(2);
      rd(6'h04, 32'h0008, "R6 read on wrap edge");
      rd(6'h04, 32'h0808, "R6 flag survives same-cycle read");
      rd(6'h04, 32'h0008, "R6 flag cleared afterwards");

      // R10: sync mode 1 on ch1
      gate[1] = 1'b0;
      wr(6'h14, 32'h003);
      idle(10);
      rd(6'h10, 32'd10, "R10 counts with gate low");
      gate[1] = 1'b1;
      idle(1);
      rd(6'h10, 32'h0, "R10 rise zeroes counter");
      rd(6'h10, 32'h1, "R10 counts with gate high");

      // R11: sync mode 2
      wr(6'h14, 32'h005);
      idle(4);
      gate[1] = 1'b0;
      rd(6'h10, 32'h4, "R11 counted while gate high");
      idle(3);
      rd(6'h10, 32'h4, "R11 held while gate low");
      gate[1] = 1'b1;
      idle(1);
      rd(6'h10, 32'h0, "R11 rise zeroes counter");
      rd(6'h10, 32'h1, "R11 counts after rise");

      // R12: sync mode 3
      wr(6'h14, 32'h007);
      rd(6'h10, 32'h0, "R12 held while gate high");
      gate[1] = 1'b0;
      idle(2);
      gate[1] = 1'b1;
      idle(1);
      rd(6'h14, 32'h0006, "R12 rise clears sync enable");
      rd(6'h10, 32'h3, "R12 free runs with gate high");

      idle(2);
      note(sb_q.size() == 0, "R1 all reads answered", 32'(sb_q.size()), 32'h0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule